// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the digital front end of a four-channel converter. A parallel host bus writes per-channel input registers. A separate transfer path copies those input registers into the output registers that feed the converters. Each input register is split into an upper byte holder and a lower nibble holder. A nibble multiplexer lets a host with a 12-bit (or wider) bus write a whole word in one access, and lets a host with an 8-bit bus write a word in two accesses.

All strobes are active low. They are sampled on the rising edge of the system clock. The load side and the transfer side are decoded separately, so a second master may own the transfer strobes. Holding both transfer strobes low makes the output registers follow the input registers. Tying the two write strobes together, and tying the byte-mode select to the transfer strobe, gives automatic update after the second byte of an 8-bit write.

Top module: `qdac_regif`

## Requirements
- R1: The channel index equals the address value: `addr` 0 selects channel 0, 1 selects channel 1, 2 selects channel 2 and 3 selects channel 3. Channel c appears on `dac_code[12*c+11:12*c]`.
- R2: An input register changes only at a rising edge where `cs_n` and `wr1_n` are both low. If either is high, a write has no effect on any input register.
- R3: A load with `full_word` high puts bus bits 11..4 into the addressed upper register and bus bits 3..0 into its lower register.
- R4: A load with `full_word` low puts bus bits 11..8 into the addressed lower register. The upper register keeps its value.
- R5: An 8-bit two-access write works as follows. The first access has `full_word` high and bus bits 3..0 at zero. The second has `full_word` low. Together they leave the word {first[11:4], second[11:8]} in the input register.
- R6: At a rising edge where `xfer_n` and `wr2_n` are both low, all four output words take their input-register contents. The new values are visible right after that edge.
- R7: While `xfer_n` and `wr2_n` stay low, a load at an edge appears on that channel's output right after the same edge.
- R8: With no transfer condition at an edge, all output words hold, whatever loads happen.
- R9: A transfer works with `cs_n` and `wr1_n` both high.
- R10: Tie `wr2_n` to `wr1_n` and `xfer_n` to `full_word`. The first access of an 8-bit write then leaves the outputs unchanged. The second access updates the addressed channel's output to the combined word.
- R11: A synchronous active-high `rst` clears every input and output register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select for input-register loads, active low |
| wr1_n | input | 1 | Load write strobe, active low |
| wr2_n | input | 1 | Transfer write strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| full_word | input | 1 | 1: load whole word; 0: load lower nibble from bus bits 11..8 |
| addr | input | 2 | Channel address |
| data_in | input | 12 | Host data bus |
| dac_code | output | 48 | Four output-register words, channel 0 in the low bits |

## Verification
The hardest case is a load and a transfer that fall on the same edge. The output must show the word being written in that cycle, not the previous content of the input register. The tied-strobe update raises the same case. Directed sequences create it in three ways: transfer strobes held low across loads, the tied-strobe two-access write, and a transfer-only master with chip select high. Seeded random cycles then mix all strobes freely, so partial nibble loads and transfers overlap in many orders.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CH_DEF   = 4;
  localparam int WORD_DEF = 12;
  localparam int HI_DEF   = 8;

  typedef struct packed {
    logic load;   // cs and first write strobe active
    logic full;   // whole-word load
    logic xfer;   // transfer and second write strobe active
  } ctl_t;
endpackage

// File: rtl/qdac_sel.sv
module qdac_sel #(
  parameter int NCH    = 4,
  parameter int ADDR_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    ld_vec
);
  always_comb begin
    ld_vec = '0;
    for (int c = 0; c < NCH; c++) begin
      if (load && (addr == ADDR_W'(c))) ld_vec[c] = 1'b1;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_vec)); // R1
  AST_SEL_NOLOAD: assert property (@(posedge clk) disable iff (rst)
    !load |-> (ld_vec == '0)); // R2
endmodule

// File: rtl/qdac_nib_mux.sv
module qdac_nib_mux #(
  parameter int WORD_W = 12,
  parameter int HI_W   = 8,
  localparam int LO_W  = WORD_W - HI_W
) (
  input  logic [WORD_W-1:0] data_in,
  input  logic              full,
  output logic [HI_W-1:0]   hi_val,
  output logic [LO_W-1:0]   lo_val
);
  assign hi_val = data_in[WORD_W-1 -: HI_W];
  assign lo_val = full ? data_in[LO_W-1:0] : data_in[WORD_W-1 -: LO_W];
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int WORD_W = 12,
  parameter int HI_W   = 8,
  localparam int LO_W  = WORD_W - HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              full,
  input  logic              xfer,
  input  logic [HI_W-1:0]   hi_val,
  input  logic [LO_W-1:0]   lo_val,
  output logic [WORD_W-1:0] code
);
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [LO_W-1:0]   lo_q, lo_n;
  logic [WORD_W-1:0] out_q;

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (ld) begin
      lo_n = lo_val;
      if (full) hi_n = hi_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      out_q <= '0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
      if (xfer) out_q <= {hi_n, lo_n};
    end
  end

  assign code = out_q;

  AST_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ld && !full) |=> $stable(hi_q)); // R4
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(hi_q) && $stable(lo_q))); // R2
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (out_q == {hi_q, lo_q})); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(out_q)); // R8
endmodule

// File: rtl/qdac_regif.sv
module qdac_regif
  import qdac_pkg::*;
#(
  parameter int NCH    = CH_DEF,
  parameter int WORD_W = WORD_DEF,
  parameter int HI_W   = HI_DEF,
  parameter int ADDR_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  wr1_n,
  input  logic                  wr2_n,
  input  logic                  xfer_n,
  input  logic                  full_word,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     data_in,
  output logic [NCH*WORD_W-1:0] dac_code
);
  localparam int LO_W = WORD_W - HI_W;

  ctl_t            ctl;
  logic [NCH-1:0]  ld_vec;
  logic [HI_W-1:0] hi_val;
  logic [LO_W-1:0] lo_val;

  assign ctl.load = !cs_n && !wr1_n;
  assign ctl.full = full_word;
  assign ctl.xfer = !xfer_n && !wr2_n;

  qdac_sel #(.NCH(NCH), .ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .load(ctl.load), .addr(addr), .ld_vec(ld_vec)
  );

  qdac_nib_mux #(.WORD_W(WORD_W), .HI_W(HI_W)) u_mux (
    .data_in(data_in), .full(ctl.full), .hi_val(hi_val), .lo_val(lo_val)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    qdac_chan #(.WORD_W(WORD_W), .HI_W(HI_W)) u_chan (
      .clk(clk), .rst(rst), .ld(ld_vec[c]), .full(ctl.full), .xfer(ctl.xfer),
      .hi_val(hi_val), .lo_val(lo_val),
      .code(dac_code[c*WORD_W +: WORD_W])
    );
  end

  AST_XFER_NOCS: assert property (@(posedge clk) disable iff (rst)
    (ctl.xfer && cs_n) |=> !$isunknown(dac_code)); // R9
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (dac_code == '0)); // R11
endmodule

// File: tb/qdac_regif_test.sv
module qdac_regif_test;
  logic        clk = 1'b0;
  logic        rst, cs_n, wr1_n, wr2_n, xfer_n, full_word;
  logic [1:0]  addr;
  logic [11:0] data_in;
  logic [47:0] dac_code;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  m_hi  [4];
  logic [3:0]  m_lo  [4];
  logic [11:0] m_out [4];

  always #10 clk = ~clk;

  qdac_regif uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n),
    .xfer_n(xfer_n), .full_word(full_word), .addr(addr),
    .data_in(data_in), .dac_code(dac_code)
  );

  function automatic logic [11:0] exp_word(int c);
    return m_out[c];
  endfunction

  task automatic model_edge(logic r, logic cs, logic w1, logic w2, logic xf,
                            logic fw, logic [1:0] a, logic [11:0] d);
    if (r) begin
      for (int c = 0; c < 4; c++) begin
        m_hi[c] = '0; m_lo[c] = '0; m_out[c] = '0;
      end
    end else begin
      if (!cs && !w1) begin
        if (fw) begin
          m_hi[a] = d[11:4]; m_lo[a] = d[3:0];
        end else begin
          m_lo[a] = d[11:8];
        end
      end
      if (!xf && !w2) begin
        for (int c = 0; c < 4; c++) m_out[c] = {m_hi[c], m_lo[c]};
      end
    end
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < 4; c++) begin
      checks++;
      if (dac_code[c*12 +: 12] !== exp_word(c)) begin
        fails++;
        $display("FAIL %s ch%0d got %h expected %h", tag, c,
                 dac_code[c*12 +: 12], exp_word(c));
      end
    end
  endtask

  task automatic cyc(string tag, logic r, logic cs, logic w1, logic w2, logic xf,
                     logic fw, logic [1:0] a, logic [11:0] d);
    rst = r; cs_n = cs; wr1_n = w1; wr2_n = w2; xfer_n = xf;
    full_word = fw; addr = a; data_in = d;
    @(posedge clk);
    model_edge(r, cs, w1, w2, xf, fw, a, d);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < 4; c++) begin
      m_hi[c] = '0; m_lo[c] = '0; m_out[c] = '0;
    end
    @(negedge clk);
    // R11: reset clears everything
    cyc("R11", 1, 1, 1, 1, 1, 1, 0, 12'hFFF);
    cyc("R11", 1, 1, 1, 1, 1, 1, 0, 12'hFFF);
    // R1 R3 R8: full-word loads per channel, outputs hold
    for (int c = 0; c < 4; c++)
      cyc("R8", 0, 0, 0, 1, 1, 1, 2'(c), 12'h111 * 12'(c + 1) + 12'h005);
    // R9 R6: transfer with chip select high exposes R1 R3 contents
    cyc("R9", 0, 1, 1, 0, 0, 1, 0, 12'h000);
    // R2: partial select does not load
    cyc("R2", 0, 1, 0, 1, 1, 1, 1, 12'hABC);
    cyc("R2", 0, 0, 1, 1, 1, 1, 2, 12'hABC);
    cyc("R2", 0, 1, 1, 0, 0, 1, 0, 12'h000);
    // R4: nibble-only load keeps upper byte
    cyc("R4", 0, 0, 0, 1, 1, 0, 2, 12'hA00);
    cyc("R4", 0, 1, 1, 0, 0, 1, 0, 12'h000);
    // R5: 8-bit two-access write on channel 1
    cyc("R5", 0, 0, 0, 1, 1, 1, 1, 12'h5C0);
    cyc("R5", 0, 0, 0, 1, 1, 0, 1, 12'h900);
    cyc("R5", 0, 1, 1, 0, 0, 1, 0, 12'h000);
    // R7: transparent outputs while transfer held
    cyc("R7", 0, 0, 0, 0, 0, 1, 3, 12'h123);
    cyc("R7", 0, 0, 0, 0, 0, 0, 3, 12'hE00);
    // R10: tied strobes, channel 0
    cyc("R10", 0, 0, 0, 0, 1, 1, 0, 12'h7E0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 12'h300);
    // seeded random traffic across R2 R3 R4 R6 R8
    for (int i = 0; i < 400; i++) begin
      logic xf_b;
      logic [1:0] a_r;
      logic [11:0] d_r;
      xf_b = ($urandom % 4) != 0;
      a_r = 2'($urandom);
      d_r = 12'($urandom);
      cyc("R6", 0, 1'($urandom), 1'($urandom), 1'($urandom), xf_b,
          1'($urandom), a_r, d_r);
    end
    // R11: reset mid-run, then a transfer shows zeros
    cyc("R11", 1, 0, 0, 0, 0, 1, 1, 12'hFFF);
    cyc("R11", 0, 1, 1, 0, 0, 1, 0, 12'h000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule